// File: doc/BRIEF.md
# External Command Handshake Unit

This unit sits between a processor's instruction decoder and the outside equipment attached to it, with no interrupt path. The processor reaches that equipment in four ways. It can fire one of eight numbered external commands and stall until that command completes. It can copy one of six external 18-bit input ports into a data register whose bits drive the data outputs at all times. It can test a synchronized external level as a branch condition. It can poll two sticky flags that external pulses set.

For each command, a configuration bit picks where its completion comes from. Either the command's own trigger pulse is looped back, or a pulse arrives on that command's external completion line. A programmable cycle limit can end a stall that never completes: the stall is released and an error flag is raised. Every external pulse and level passes through a two-flop synchronizer before the unit uses it.

Top module: `xcmd_unit`

## Requirements
- R1: `op` is encoded as 0 none, 1 trigger, 2 load, 3 sense read, and `arg` is its 3-bit operand. A trigger accepted at a clock edge drives `trig_out[arg]` high, and only that bit, for exactly the one cycle after that edge. `busy` rises at the same edge.
- R2: When `loop_cfg[n]` is 1, command n completes from its own trigger pulse, so `busy` stays high for exactly one cycle.
- R3: When `loop_cfg[n]` is 0, `busy` stays high until the third clock edge after `done_in[n]` rises and then falls at that edge. Pulses on the other `done_in` bits are ignored.
- R4: When `to_limit` is L, nonzero, and no completion arrives, `busy` falls at the L-th edge after the issuing edge and `timeout_err` rises at the same edge. A `to_limit` of 0 waits indefinitely. The next accepted trigger clears `timeout_err`.
- R5: Any request presented while `busy` is high is ignored: no trigger pulse, no load, no flag clear.
- R6: A load with `arg` from 0 to 5 copies `port_in[18*arg+17 : 18*arg]` into the data register, visible on `data_out` after the accepting edge. A load with `arg` of 6 or 7 leaves the register unchanged.
- R7: `data_out` always shows the full 18-bit data register.
- R8: `level_cond` follows `level_in` two clock edges later.
- R9: A rising pulse on `sense_in[k]` sets flag k at the third edge after the rise. `sense_val` shows flag `arg[0]` combinationally. A sense read clears the selected flag at the accepting edge.
- R10: If a synchronized pulse for a flag lands at the same edge as a read of that flag, the flag stays set.
- R11: After reset, `trig_out`, `busy`, `timeout_err`, `data_out` and both flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 2 | Request code: 0 none, 1 trigger, 2 load, 3 sense read |
| arg | input | 3 | Command number, port index or flag index (bit 0) |
| loop_cfg | input | 8 | Per-command completion source, 1 = own trigger |
| to_limit | input | 16 | Stall cycle limit, 0 = no limit |
| done_in | input | 8 | Asynchronous external completion pulses |
| port_in | input | 108 | Six 18-bit input ports, port k at bits 18k+17..18k |
| level_in | input | 1 | Asynchronous level for branch sensing |
| sense_in | input | 2 | Asynchronous pulses that set the sense flags |
| trig_out | output | 8 | One-cycle command trigger pulses |
| busy | output | 1 | Processor stall while a command is outstanding |
| timeout_err | output | 1 | Last command ended by the cycle limit |
| data_out | output | 18 | Data register, driven continuously |
| level_cond | output | 1 | Synchronized level condition |
| sense_val | output | 1 | Value of the flag selected by arg[0] |

## Verification
Results fall due at different distances from the stimulus. Triggers, loads, flag clears and `busy` from a looped-back command change at the first edge after a request. `level_cond` changes at the second edge after its input moves. External completions and sense pulses take effect at the third edge. A timeout lands at the edge numbered by the limit. The bench drives every input on a falling edge and counts falling edges to the edge where each result is due. It checks one falling edge before that point, to show that nothing has happened early, and on the falling edge right after it.

// File: rtl/xcmd_pkg.sv
package xcmd_pkg;
    localparam int DW     = 18;
    localparam int NCMD   = 8;
    localparam int NPORT  = 6;
    localparam int NSENSE = 2;
    localparam int SELW   = $clog2(NCMD);
    localparam int TOW    = 16;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_TRIG  = 2'd1,
        OP_LOAD  = 2'd2,
        OP_SENSE = 2'd3
    } xcmd_op_e;

    typedef struct packed {
        logic            valid;
        xcmd_op_e        op;
        logic [SELW-1:0] arg;
    } xcmd_req_t;

    function automatic logic [NCMD-1:0] cmd_onehot(input logic [SELW-1:0] sel);
        logic [NCMD-1:0] v;
        v = '0;
        v[sel] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/xcmd_sync.sv
module xcmd_sync #(
    parameter int W    = 1,
    parameter bit EDGE = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] q
);
    logic [W-1:0] s1, s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            s2 <= '0;
        end else begin
            s1 <= async_in;
            s2 <= s1;
        end
    end

    generate
        if (EDGE) begin : g_edge
            logic [W-1:0] s3;
            always_ff @(posedge clk) begin
                if (rst) s3 <= '0;
                else     s3 <= s2;
            end
            assign q = s2 & ~s3;
        end else begin : g_level
            assign q = s2;
        end
    endgenerate
endmodule

// File: rtl/xcmd_handshake.sv
module xcmd_handshake
    import xcmd_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [SELW-1:0] sel,
    input  logic [NCMD-1:0] loop_cfg,
    input  logic [NCMD-1:0] done_rise,
    input  logic [TOW-1:0]  limit,
    output logic [NCMD-1:0] trig_out,
    output logic            busy,
    output logic            err
);
    logic [SELW-1:0] pend;
    logic [TOW-1:0]  cnt;
    logic            hit;
    logic            expire;

    always_comb begin
        if (loop_cfg[pend]) hit = trig_out[pend];
        else                hit = done_rise[pend];
        expire = (limit != '0) && ((cnt + TOW'(1)) == limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_out <= '0;
            busy     <= 1'b0;
            err      <= 1'b0;
            pend     <= '0;
            cnt      <= '0;
        end else begin
            trig_out <= '0;
            if (start) begin
                trig_out <= cmd_onehot(sel);
                pend     <= sel;
                busy     <= 1'b1;
                err      <= 1'b0;
                cnt      <= '0;
            end else if (busy) begin
                if (hit) begin
                    busy <= 1'b0;
                end else if (expire) begin
                    busy <= 1'b0;
                    err  <= 1'b1;
                end else begin
                    cnt <= cnt + TOW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/xcmd_inmux.sv
module xcmd_inmux
    import xcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [SELW-1:0]   sel,
    input  logic [NPORT*DW-1:0] ports,
    output logic [DW-1:0]     data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
        end else if (load && (int'(sel) < NPORT)) begin
            data <= ports[sel*DW +: DW];
        end
    end
endmodule

// File: rtl/xcmd_sense.sv
module xcmd_sense
    import xcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NSENSE-1:0] rise,
    input  logic              clr,
    input  logic              idx,
    output logic [NSENSE-1:0] flags
);
    logic [NSENSE-1:0] clr_vec;

    always_comb begin
        clr_vec = '0;
        clr_vec[idx] = clr;
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~clr_vec) | rise;
    end
endmodule

// File: rtl/xcmd_unit.sv
module xcmd_unit
    import xcmd_pkg::*;
(
    input  logic [0:0]          clk,
    input  logic                rst,
    input  logic [1:0]          op,
    input  logic [2:0]          arg,
    input  logic [7:0]          loop_cfg,
    input  logic [15:0]         to_limit,
    input  logic [7:0]          done_in,
    input  logic [107:0]        port_in,
    input  logic                level_in,
    input  logic [1:0]          sense_in,
    output logic [7:0]          trig_out,
    output logic                busy,
    output logic                timeout_err,
    output logic [17:0]         data_out,
    output logic                level_cond,
    output logic                sense_val
);
    xcmd_req_t         req;
    logic [NCMD-1:0]   done_rise;
    logic [NSENSE-1:0] sense_rise;
    logic [NSENSE-1:0] flags;

    always_comb begin
        req.op    = xcmd_op_e'(op);
        req.arg   = arg;
        req.valid = (req.op != OP_NONE) && !busy;
    end

    xcmd_sync #(.W(NCMD), .EDGE(1'b1)) i_done_sync (
        .clk(clk), .rst(rst), .async_in(done_in), .q(done_rise)
    );

    xcmd_sync #(.W(NSENSE), .EDGE(1'b1)) i_sense_sync (
        .clk(clk), .rst(rst), .async_in(sense_in), .q(sense_rise)
    );

    xcmd_sync #(.W(1), .EDGE(1'b0)) i_level_sync (
        .clk(clk), .rst(rst), .async_in(level_in), .q(level_cond)
    );

    xcmd_handshake i_hs (
        .clk(clk), .rst(rst),
        .start(req.valid && req.op == OP_TRIG),
        .sel(req.arg),
        .loop_cfg(loop_cfg),
        .done_rise(done_rise),
        .limit(to_limit),
        .trig_out(trig_out),
        .busy(busy),
        .err(timeout_err)
    );

    xcmd_inmux i_mux (
        .clk(clk), .rst(rst),
        .load(req.valid && req.op == OP_LOAD),
        .sel(req.arg),
        .ports(port_in),
        .data(data_out)
    );

    xcmd_sense i_sense (
        .clk(clk), .rst(rst),
        .rise(sense_rise),
        .clr(req.valid && req.op == OP_SENSE),
        .idx(req.arg[0]),
        .flags(flags)
    );

    assign sense_val = flags[arg[0]];
endmodule

// File: rtl/xcmd_unit_chk.sv
module xcmd_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic [7:0]  trig_out,
    input logic        busy,
    input logic        timeout_err,
    input logic [17:0] data_out
);
    a_r1_trig_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(trig_out));

    a_r1_trig_single_cycle: assert property (@(posedge clk) disable iff (rst)
        (trig_out != 8'd0) |=> (trig_out == 8'd0));

    a_r1_trig_with_busy: assert property (@(posedge clk) disable iff (rst)
        (trig_out != 8'd0) |-> busy);

    a_r5_data_held_while_busy: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(data_out));

    a_r4_timeout_releases: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_err) |-> !busy);
endmodule

bind xcmd_unit xcmd_unit_chk i_chk (
    .clk(clk), .rst(rst), .trig_out(trig_out), .busy(busy),
    .timeout_err(timeout_err), .data_out(data_out)
);

// File: tb/test_xcmd_unit.sv
module test_xcmd_unit;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   op = 2'd0;
    logic [2:0]   arg = 3'd0;
    logic [7:0]   loop_cfg = 8'b0000_1000;
    logic [15:0]  to_limit = 16'd0;
    logic [7:0]   done_in = 8'd0;
    logic [107:0] port_in;
    logic         level_in = 1'b0;
    logic [1:0]   sense_in = 2'd0;
    logic [7:0]   trig_out;
    logic         busy, timeout_err, level_cond, sense_val;
    logic [17:0]  data_out;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    localparam logic [17:0] P0 = 18'h01234, P1 = 18'h2ABCD, P2 = 18'h3FFFF,
                            P3 = 18'h00001, P4 = 18'h15555, P5 = 18'h2AAAA;
    localparam int NV = 9;
    localparam logic [20:0] LOAD_VEC [NV] = '{
        {3'd0, P0}, {3'd1, P1}, {3'd2, P2}, {3'd3, P3}, {3'd4, P4},
        {3'd5, P5}, {3'd6, P5}, {3'd7, P5}, {3'd3, P3}
    };

    assign port_in = {P5, P4, P3, P2, P1, P0};

    always #2 clk = ~clk;

    xcmd_unit i_xcmd_unit (
        .clk(clk), .rst(rst), .op(op), .arg(arg), .loop_cfg(loop_cfg),
        .to_limit(to_limit), .done_in(done_in), .port_in(port_in),
        .level_in(level_in), .sense_in(sense_in), .trig_out(trig_out),
        .busy(busy), .timeout_err(timeout_err), .data_out(data_out),
        .level_cond(level_cond), .sense_val(sense_val)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic issue(input logic [1:0] o, input logic [2:0] a);
        op = o; arg = a;
        @(negedge clk);
        op = 2'd0;
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        // R11 reset state
        chk("R11 trig", trig_out, 0);
        chk("R11 busy", busy, 0);
        chk("R11 err", timeout_err, 0);
        chk("R11 data", data_out, 0);
        arg = 3'd0; #0 chk("R11 flag0", sense_val, 0);
        arg = 3'd1; #0 chk("R11 flag1", sense_val, 0);

        // R6 R7 load table
        for (int i = 0; i < NV; i++) begin
            issue(2'd2, LOAD_VEC[i][20:18]);
            chk("R6 R7 load", data_out, LOAD_VEC[i][17:0]);
        end

        // R1 R2 looped-back trigger on command 3
        issue(2'd1, 3'd3);
        chk("R1 trig pulse", trig_out, 8'h08);
        chk("R1 busy rises", busy, 1);
        tick(1);
        chk("R1 trig one cycle", trig_out, 0);
        chk("R2 busy one cycle", busy, 0);

        // R3 external completion on command 5, limit 0
        issue(2'd1, 3'd5);
        chk("R1 trig cmd5", trig_out, 8'h20);
        tick(1);
        done_in[2] = 1'b1;
        tick(2);
        done_in[2] = 1'b0;
        tick(3);
        chk("R3 R4 other done ignored, no limit", busy, 1);
        // R5 requests ignored while busy
        issue(2'd2, 3'd0);
        chk("R5 load ignored", data_out, P3);
        issue(2'd1, 3'd3);
        chk("R5 trig ignored", trig_out, 0);
        done_in[5] = 1'b1;
        tick(2);
        chk("R3 not early", busy, 1);
        done_in[5] = 1'b0;
        tick(1);
        chk("R3 completion third edge", busy, 0);

        // R4 timeout with limit 4 on command 1
        to_limit = 16'd4;
        issue(2'd1, 3'd1);
        tick(3);
        chk("R4 busy before limit", busy, 1);
        chk("R4 no err before limit", timeout_err, 0);
        tick(1);
        chk("R4 busy released", busy, 0);
        chk("R4 err set", timeout_err, 1);
        issue(2'd1, 3'd3);
        chk("R4 err cleared", timeout_err, 0);
        tick(1);
        to_limit = 16'd0;

        // R8 level sense
        level_in = 1'b1;
        tick(1);
        chk("R8 level not early", level_cond, 0);
        tick(1);
        chk("R8 level second edge", level_cond, 1);

        // R9 sense flag 1
        arg = 3'd1;
        sense_in[1] = 1'b1;
        tick(2);
        chk("R9 flag not early", sense_val, 0);
        sense_in[1] = 1'b0;
        tick(1);
        chk("R9 flag set", sense_val, 1);
        arg = 3'd0; #0 chk("R9 other flag clear", sense_val, 0);

        // R9 set flag 0, then R10 collision with a read
        sense_in[0] = 1'b1;
        tick(2);
        sense_in[0] = 1'b0;
        tick(3);
        chk("R9 flag0 set", sense_val, 1);
        sense_in[0] = 1'b1;
        tick(2);
        sense_in[0] = 1'b0;
        issue(2'd3, 3'd0);
        chk("R10 pulse wins over read", sense_val, 1);
        tick(2);
        issue(2'd3, 3'd0);
        chk("R9 read clears", sense_val, 0);
        arg = 3'd1; #0 chk("R9 flag1 kept", sense_val, 1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule